// File: doc/BRIEF.md
# Per-Pin Register GPIO Controller

This block is a memory-mapped GPIO controller. Each pad has its own byte-wide control register. The register holds the pad's synchronised input level, the value to drive, and an active-low enable for the output driver. The registers sit on a 4-byte stride in a sparse 9-bit byte address space. There are five groups of pins with holes between them:

| Group base | Pins | Pin indices |
|---|---|---|
| 0x050 | 4 | 0–3 |
| 0x088 | 16 | 4–19 |
| 0x140 | 6 | 20–25 |
| 0x188 | 2 | 26–27 |
| 0x1C0 | 4 | 28–31 |

Software sets a pin's direction and drive level with one byte write. It can read both bits back, for example to save and restore pin state around a power-down that wipes the registers.

The last group of four pins can raise interrupt requests on the parent interrupt controller. Each of these pins has a mask bit, a level/edge choice and a polarity choice. These settings live in two byte registers just above the pin map. The request lines come out on a 32-line parent vector at fixed positions.

Top module: `gpio_pinreg_ctrl`

## Requirements
- R1: After reset every pin register reads 0x20 while its pad input is 0, meaning output value 0 and output disabled. pad_oe_o and pad_out_o are all zero, and both interrupt configuration registers read 0x00.
- R2: A write to a pin register at a word-aligned mapped address loads bit 4 into the pin's output value and bit 5 into its active-low enable. The pad then shows pad_out_o = bit 4 and pad_oe_o = NOT bit 5 after the clock edge that takes the write.
- R3: Bit 0 of a pin register is read-only and returns the pad input after a two-flop synchroniser. A read taken at the third clock edge after the pad changes shows the new level; reads taken at the first and second edges still show the old level.
- R4: Bits 1, 2, 3, 6 and 7 of a pin register always read 0, and writing ones to them or to bit 0 changes nothing.
- R5: Pin i of a group sits at byte address base + 4*i. The groups and their bases are listed in the table above, and pins are numbered across the groups in ascending address order.
- R6: Reads of any address that is not word aligned, falls in a gap between groups, or lies past the last register return 0x00. Writes to such addresses change no pin and no configuration state.
- R7: Bits 4 and 5 of every pin read back exactly as last written. This lets software save and restore the pin state.
- R8: The pins at 0x1C0, 0x1C4, 0x1C8 and 0x1CC drive parent interrupt lines 28, 29, 30 and 31 in that order. No other line of parent_irq_o is ever asserted.
- R9: In level mode a request line is high while its synchronised input equals the polarity bit (1 = high, 0 = low). It follows a pad change three clock edges later.
- R10: In edge mode a request line gives a one-cycle pulse three clock edges after a pad transition in the chosen direction (polarity 1 = rising, 0 = falling).
- R11: A request line is low from the second clock edge after its mask bit is cleared, and stays low while it is masked.
- R12: The register at 0x1E0 holds the mask bits in bits 3:0 (bit k unmasks interrupt pin k, 1 = enabled); its bits 7:4 read 0. The register at 0x1E4 holds the edge-mode bits in bits 3:0 (1 = edge) and the polarity bits in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid after the edge that takes the read |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| pad_out_o | output | 32 | Value driven onto each pad |
| pad_oe_o | output | 32 | Output driver enable per pad, active high |
| parent_irq_o | output | 32 | Interrupt request lines to the parent controller |

## Verification
A write takes effect on the pad outputs at the clock edge that captures it. The bench checks the pads at the falling edge right after that edge. Read data is registered, so the scoreboard takes an expected value when the read is issued and compares it at the falling edge after the capturing edge. The input path takes three edges from a pad change to a visible read or request: two synchroniser stages and then the read or request register. The bench therefore issues reads and checks request lines at each of those edges, and expects the old value before the third. An edge pulse is checked high at that edge and low one cycle later, and a cleared mask is checked to take effect at the second edge.

// File: rtl/gpio_pinreg_pkg.sv
package gpio_pinreg_pkg;
  localparam int unsigned GRP_N = 5;
  localparam int unsigned GRP_BASE [GRP_N] = '{32'h050, 32'h088, 32'h140, 32'h188, 32'h1C0};
  localparam int unsigned GRP_PINS [GRP_N] = '{4, 16, 6, 2, 4};
  localparam int unsigned STRIDE = 4;
  localparam int unsigned IRQ_GRP = 4;
  localparam int unsigned CFG_EN_OFS = 32'h1E0;
  localparam int unsigned CFG_MODE_OFS = 32'h1E4;
  localparam int unsigned PARENT_BASE = 28;
  localparam int unsigned PARENT_LINES = 32;
  localparam int unsigned BIT_IN = 0;
  localparam int unsigned BIT_OUT = 4;
  localparam int unsigned BIT_OEN = 5;
  localparam int unsigned POL_LSB = 4;

  function automatic int unsigned grp_first(int unsigned g);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < GRP_N; i++)
      if (i < g) s += GRP_PINS[i];
    return s;
  endfunction

  localparam int unsigned PIN_TOTAL = grp_first(GRP_N);
endpackage

// File: rtl/gpio_pinreg_sync.sv
module gpio_pinreg_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_pinreg_dec.sv
module gpio_pinreg_dec
  import gpio_pinreg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned NUM_PINS = PIN_TOTAL,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pin_hit_o,
  output logic [IDX_W-1:0]  pin_idx_o,
  output logic              cfg_en_hit_o,
  output logic              cfg_mode_hit_o
);
  always_comb begin
    int unsigned a;
    a = 32'(addr_i);
    pin_hit_o = 1'b0;
    pin_idx_o = '0;
    // one range compare per group; holes fall through
    for (int unsigned g = 0; g < GRP_N; g++) begin
      if (a >= GRP_BASE[g] && a < GRP_BASE[g] + STRIDE * GRP_PINS[g] && (a % STRIDE) == 0) begin
        pin_hit_o = 1'b1;
        pin_idx_o = IDX_W'(grp_first(g) + (a - GRP_BASE[g]) / STRIDE);
      end
    end
    cfg_en_hit_o   = (a == CFG_EN_OFS);
    cfg_mode_hit_o = (a == CFG_MODE_OFS);
  end
endmodule

// File: rtl/gpio_pinreg_irq.sv
module gpio_pinreg_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] prev_q, req_q, hit;

  assign hit = (edge_i & ((pol_i & lvl_i & ~prev_q) | (~pol_i & ~lvl_i & prev_q)))
             | (~edge_i & ~(lvl_i ^ pol_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      req_q  <= en_i & hit;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/gpio_pinreg_ctrl.sv
module gpio_pinreg_ctrl
  import gpio_pinreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned NUM_PINS  = PIN_TOTAL,
  parameter int unsigned PARENT_W  = PARENT_LINES,
  parameter int unsigned IRQ_N     = GRP_PINS[IRQ_GRP],
  parameter int unsigned IRQ_FIRST = grp_first(IRQ_GRP),
  parameter int unsigned PARENT_LO = PARENT_BASE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [PARENT_W-1:0] parent_irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PINS);

  logic             pin_hit, cfg_en_hit, cfg_mode_hit, wr;
  logic [IDX_W-1:0] pin_idx;
  logic [NUM_PINS-1:0] out_q, oen_q, in_sync;
  logic [IRQ_N-1:0] irq_en_q, irq_edge_q, irq_pol_q, irq_req;
  logic [7:0]       rd_val, rdata_q;

  assign wr = req_i & we_i;

  gpio_pinreg_dec #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .addr_i        (addr_i),
    .pin_hit_o     (pin_hit),
    .pin_idx_o     (pin_idx),
    .cfg_en_hit_o  (cfg_en_hit),
    .cfg_mode_hit_o(cfg_mode_hit)
  );

  gpio_pinreg_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q[p] <= 1'b0;
        oen_q[p] <= 1'b1;
      end else if (wr && pin_hit && pin_idx == IDX_W'(p)) begin
        out_q[p] <= wdata_i[BIT_OUT];
        oen_q[p] <= wdata_i[BIT_OEN];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q   <= '0;
      irq_edge_q <= '0;
      irq_pol_q  <= '0;
    end else if (wr) begin
      if (cfg_en_hit) irq_en_q <= wdata_i[IRQ_N-1:0];
      if (cfg_mode_hit) begin
        irq_edge_q <= wdata_i[IRQ_N-1:0];
        irq_pol_q  <= wdata_i[POL_LSB +: IRQ_N];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (pin_hit) begin
      rd_val[BIT_IN]  = in_sync[pin_idx];
      rd_val[BIT_OUT] = out_q[pin_idx];
      rd_val[BIT_OEN] = oen_q[pin_idx];
    end else if (cfg_en_hit) begin
      rd_val[IRQ_N-1:0] = irq_en_q;
    end else if (cfg_mode_hit) begin
      rd_val[IRQ_N-1:0]         = irq_edge_q;
      rd_val[POL_LSB +: IRQ_N]  = irq_pol_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (req_i && !we_i)    rdata_q <= rd_val;
  end

  gpio_pinreg_irq #(.N(IRQ_N)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (in_sync[IRQ_FIRST +: IRQ_N]),
    .en_i  (irq_en_q),
    .edge_i(irq_edge_q),
    .pol_i (irq_pol_q),
    .req_o (irq_req)
  );

  always_comb begin
    parent_irq_o = '0;
    parent_irq_o[PARENT_LO +: IRQ_N] = irq_req;
  end

  assign rdata_o   = rdata_q;
  assign pad_out_o = out_q;
  assign pad_oe_o  = ~oen_q;
endmodule

// File: rtl/gpio_pinreg_ctrl_chk.sv
module gpio_pinreg_ctrl_chk #(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned PARENT_W  = 32,
  parameter int unsigned IRQ_N     = 4,
  parameter int unsigned PARENT_LO = 28
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [PARENT_W-1:0] parent_irq_o,
  input logic [IRQ_N-1:0]    irq_en_q,
  input logic [IRQ_N-1:0]    irq_edge_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_reset_all_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (pad_oe_o == '0 && pad_out_o == '0));

  a_r6_pads_move_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(pad_oe_o) && $stable(pad_out_o)));

  for (genvar k = 0; k < IRQ_N; k++) begin : g_line
    a_r11_masked_line_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_en_q[k] |=> !parent_irq_o[PARENT_LO + k]);

    a_r10_edge_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(req_i && we_i) && irq_edge_q[k] && parent_irq_o[PARENT_LO + k])
        |=> !parent_irq_o[PARENT_LO + k]);
  end
endmodule

bind gpio_pinreg_ctrl gpio_pinreg_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .PARENT_W (PARENT_W),
  .IRQ_N    (IRQ_N),
  .PARENT_LO(PARENT_LO)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .parent_irq_o(parent_irq_o),
  .irq_en_q    (irq_en_q),
  .irq_edge_q  (irq_edge_q)
);

// File: tb/gpio_pinreg_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pinreg_ctrl_bench;
  localparam int NP = 32;
  localparam int BB [5] = '{'h050, 'h088, 'h140, 'h188, 'h1C0};
  localparam int PP [5] = '{4, 16, 6, 2, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [31:0] pirq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;
  logic [NP-1:0] e_oe, e_out;

  always #4 clk = ~clk;

  gpio_pinreg_ctrl u_gpio_pinreg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .parent_irq_o(pirq)
  );

  function automatic int pin_addr(int p);
    int r = p;
    for (int g = 0; g < 5; g++) begin
      if (r < PP[g]) return BB[g] + 4 * r;
      r -= PP[g];
    end
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [7:0] d);
    req = 1'b1; we = 1'b1; addr = 9'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(int a, logic [7:0] exp, string tag);
    req = 1'b1; we = 1'b0; addr = 9'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= req && !we;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'h0, rdata}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 irq", pirq, '0);
    bus_read('h050, 8'h20, "R1 pin0 reset");
    bus_read('h1CC, 8'h20, "R1 pin31 reset");
    bus_read('h1E0, 8'h00, "R1 cfg en reset");
    bus_read('h1E4, 8'h00, "R1 cfg mode reset");

    // R2 write layout
    bus_write('h050, 8'h10);
    check("R2 oe after out=1 oen=0", {31'h0, pad_oe[0]}, 1);
    check("R2 out after out=1 oen=0", {31'h0, pad_out[0]}, 1);
    bus_write('h050, 8'h30);
    check("R2 oe released", {31'h0, pad_oe[0]}, 0);
    bus_read('h050, 8'h30, "R7 readback 0x30");

    // R4 unused bits and bit0 ignored
    bus_write('h088, 8'hCF);
    check("R4 oe pin4", {31'h0, pad_oe[4]}, 1);
    check("R4 out pin4", {31'h0, pad_out[4]}, 0);
    bus_read('h088, 8'h00, "R4 unused bits read 0");

    // R3 synchroniser latency on pin5 (0x08C)
    pad_in[5] = 1'b1;
    bus_read('h08C, 8'h20, "R3 edge1 old");
    bus_read('h08C, 8'h20, "R3 edge2 old");
    bus_read('h08C, 8'h21, "R3 edge3 new");
    pad_in[5] = 1'b0;
    idle(3);
    bus_read('h08C, 8'h20, "R3 back to 0");

    // R5/R7 all pins through the sparse map
    for (int p = 0; p < NP; p++) begin
      bus_write(pin_addr(p), {2'b00, p[1], p[0], 4'h0});
      e_oe[p] = ~p[1];
      e_out[p] = p[0];
    end
    check("R5 pad_oe map", pad_oe, e_oe);
    check("R5 pad_out map", pad_out, e_out);
    for (int p = 0; p < NP; p++)
      bus_read(pin_addr(p), {2'b00, 1'(p >> 1), 1'(p), 4'h0}, $sformatf("R7 readback pin %0d", p));

    // R6 unmapped
    bus_write('h060, 8'h30);
    bus_write('h051, 8'h30);
    bus_write('h0C8, 8'h10);
    bus_write('h1D0, 8'h10);
    bus_write('h1FC, 8'h10);
    bus_write('h1E8, 8'hFF);
    check("R6 pad_oe unchanged", pad_oe, e_oe);
    check("R6 pad_out unchanged", pad_out, e_out);
    bus_read('h060, 8'h00, "R6 gap read");
    bus_read('h051, 8'h00, "R6 misaligned read");
    bus_read('h0C8, 8'h00, "R6 after group read");
    bus_read('h1FC, 8'h00, "R6 top read");
    bus_read('h1E0, 8'h00, "R6 cfg untouched");

    // R12 config registers
    bus_write('h1E0, 8'hFF);
    bus_read('h1E0, 8'h0F, "R12 en upper bits 0");
    bus_write('h1E4, 8'hA5);
    bus_read('h1E4, 8'hA5, "R12 mode readback");

    // line0 level-high, line1 level-low, line2 rising, line3 falling
    bus_write('h1E4, 8'h5C);
    idle(3);
    check("R9 level-low asserted, R8 only line 29", pirq, 32'h2000_0000);
    pad_in[28] = 1'b1; pad_in[30] = 1'b1; pad_in[31] = 1'b1;
    idle(2);
    check("R9 not yet at edge2", pirq, 32'h2000_0000);
    idle(1);
    check("R10 rising pulse, R9 level high", pirq, 32'h7000_0000);
    idle(1);
    check("R10 pulse one cycle", pirq, 32'h3000_0000);
    pad_in[31] = 1'b0;
    idle(3);
    check("R10 falling pulse", pirq, 32'hB000_0000);
    idle(1);
    check("R10 falling pulse ends", pirq, 32'h3000_0000);
    pad_in[0] = 1'b1; pad_in[27] = 1'b1;
    idle(4);
    check("R8 other pins no request", pirq, 32'h3000_0000);

    // R11 mask
    bus_write('h1E0, 8'h00);
    check("R11 still set at edge1", pirq, 32'h3000_0000);
    idle(1);
    check("R11 masked at edge2", pirq, 32'h0000_0000);
    pad_in[30] = 1'b0; idle(1); pad_in[30] = 1'b1;
    idle(4);
    check("R11 masked edge ignored", pirq, 32'h0000_0000);

    idle(3);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule